// File: doc/BRIEF.md
# Inverted Page Table Lookup Unit

This unit holds one page register for each physical frame. All processes share the one table. A request names a process ID and a virtual page number. The unit hashes that pair to a starting slot. It then examines one slot per clock and moves to the next slot on a tag mismatch. The walk ends at a matching slot (a hit), at a never-used slot (a miss), or after every slot has been examined once (a miss). The frame number is not stored anywhere: it is the index of the slot that matched. A hit returns the frame, the physical address formed from that frame and the request's page offset, and the slot's protection, dirty and used bits.

The same walk serves two other commands. Insert claims the first slot on the walk that holds no live mapping and reports the frame it took. Invalidate removes a live mapping but leaves the slot marked as occupied. Later walks therefore still step past the removed mapping, and a later insert may reuse that slot. Only one command is in progress at a time. A busy flag covers the probe cycles, and requests presented while busy are dropped.

Top module: `ipt_lookup_unit`

## Requirements
- R1: After reset, busy_o and rsp_valid_o are low, every slot is unused, and every lookup misses.
- R2: The starting slot is the low IDX_W bits of the virtual page number XORed with the process ID folded to IDX_W bits, where process ID bit i is XORed into hash bit (i mod IDX_W). An insert into an empty table lands in that starting slot.
- R3: A command code is given on req_op_i: 0 is lookup, 1 is insert, 2 is invalidate, and 3 acts as lookup. A lookup hit returns rsp_hit_o=1, rsp_frame_o equal to the matching slot index, rsp_paddr_o = {frame, req_off_i}, and the protection bits stored at insert. On a miss the frame and protection outputs are zero, and rsp_paddr_o is {0, offset}.
- R4: The stored tag is the pair of process ID and page number. A request with the same page number but a different process ID does not hit that entry.
- R5: On a collision, insert probes slot (index+1) mod NUM_SLOTS and wraps from the last slot to slot 0.
- R6: A lookup walks past occupied slots whose tags mismatch. It reports a hit at a later matching slot, and a miss at the first never-used slot.
- R7: If all NUM_SLOTS slots are examined without a result, the command ends. An insert into a full table reports rsp_hit_o=0, and a lookup of an absent key in a full table misses.
- R8: Invalidate of a live key reports a hit and removes the mapping, so that a later lookup of that key misses. Keys stored beyond the removed slot on the same walk are still found. Invalidate of an absent key reports a miss.
- R9: Insert reuses the first removed (invalidated) slot on its walk.
- R10: A lookup hit reports the dirty and used bits as they were before that access. The hit then sets used, and it sets dirty when req_write_i is high. Insert clears both bits.
- R11: A request is accepted when req_valid_i is high while busy_o is low. busy_o is high from the next cycle through the last probe cycle. rsp_valid_o pulses for one cycle after that, with busy_o low. Requests presented while busy_o is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | Command code (0 lookup, 1 insert, 2 invalidate) |
| req_pid_i | input | PID_W | Process ID |
| req_vpn_i | input | VPN_W | Virtual page number |
| req_off_i | input | OFF_W | Page offset |
| req_prot_i | input | PROT_W | Protection bits for insert |
| req_write_i | input | 1 | Lookup is a write access (sets dirty) |
| busy_o | output | 1 | Walk in progress |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_hit_o | output | 1 | Hit, or insert success |
| rsp_frame_o | output | IDX_W | Frame number (slot index) |
| rsp_paddr_o | output | IDX_W+OFF_W | Physical address |
| rsp_prot_o | output | PROT_W | Protection bits |
| rsp_dirty_o | output | 1 | Dirty bit before the access |
| rsp_used_o | output | 1 | Used bit before the access |

## Verification
The bench builds the unit with NUM_SLOTS=8, PID_W=4, VPN_W=10, OFF_W=8 and PROT_W=3. With eight slots, a handful of inserts creates collisions, wraps the walk past slot 7, and fills the table, so a full eight-probe walk is exercised. Because PID_W is wider than the three-bit index, the high process-ID bit must fold back into the hash.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_INSERT = 2'd1,
    OP_INVAL  = 2'd2,
    OP_RSVD   = 2'd3
  } ipt_op_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int PID_W = 6,
  parameter int VPN_W = 20,
  parameter int IDX_W = 4
) (
  input  logic [PID_W-1:0] pid_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = vpn_i[IDX_W-1:0];
    for (int i = 0; i < PID_W; i++) begin
      idx_o[i % IDX_W] = idx_o[i % IDX_W] ^ pid_i[i];
    end
  end
endmodule

// File: rtl/ipt_slot_array.sv
module ipt_slot_array #(
  parameter int NUM_SLOTS = 16,
  parameter int ENTRY_W   = 33,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [ENTRY_W-1:0] wr_data_i
);
  logic [ENTRY_W-1:0] slots [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slots[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g)) slots[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slots[rd_idx_i];
endmodule

// File: rtl/ipt_probe_ctrl.sv
module ipt_probe_ctrl
  import ipt_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int PID_W     = 6,
  parameter int VPN_W     = 20,
  parameter int OFF_W     = 12,
  parameter int PROT_W    = 3,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int ENTRY_W  = 4 + PROT_W + PID_W + VPN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         req_op_i,
  input  logic [PID_W-1:0]   req_pid_i,
  input  logic [VPN_W-1:0]   req_vpn_i,
  input  logic [OFF_W-1:0]   req_off_i,
  input  logic [PROT_W-1:0]  req_prot_i,
  input  logic               req_write_i,
  input  logic [IDX_W-1:0]   start_idx_i,
  output logic [IDX_W-1:0]   rd_idx_o,
  input  logic [ENTRY_W-1:0] rd_data_i,
  output logic               wr_en_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic [ENTRY_W-1:0] wr_data_o,
  output logic               busy_o,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic [IDX_W-1:0]   rsp_frame_o,
  output logic [IDX_W+OFF_W-1:0] rsp_paddr_o,
  output logic [PROT_W-1:0]  rsp_prot_o,
  output logic               rsp_dirty_o,
  output logic               rsp_used_o
);
  typedef struct packed {
    logic              occ;
    logic              live;
    logic              dirty;
    logic              used;
    logic [PROT_W-1:0] prot;
    logic [PID_W-1:0]  pid;
    logic [VPN_W-1:0]  vpn;
  } slot_t;

  typedef enum logic {S_IDLE, S_PROBE} state_e;

  state_e            state_q;
  ipt_op_e           op_q;
  logic [PID_W-1:0]  pid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFF_W-1:0]  off_q;
  logic [PROT_W-1:0] prot_q;
  logic              write_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  frame_q;

  slot_t cur, nxt_e;
  logic  match, last, done, hit;

  assign cur      = slot_t'(rd_data_i);
  assign rd_idx_o = idx_q;
  assign wr_idx_o = idx_q;
  assign busy_o   = (state_q == S_PROBE);
  assign match    = cur.occ && cur.live && cur.pid == pid_q && cur.vpn == vpn_q;
  assign last     = (cnt_q == IDX_W'(NUM_SLOTS - 1));

  always_comb begin
    done    = 1'b0;
    hit     = 1'b0;
    wr_en_o = 1'b0;
    nxt_e   = cur;
    if (state_q == S_PROBE) begin
      if (op_q == OP_INSERT) begin
        if (!cur.occ || !cur.live) begin
          done    = 1'b1;
          hit     = 1'b1;
          wr_en_o = 1'b1;
          nxt_e   = '{occ: 1'b1, live: 1'b1, dirty: 1'b0, used: 1'b0,
                      prot: prot_q, pid: pid_q, vpn: vpn_q};
        end else if (last) done = 1'b1;
      end else begin
        if (match) begin
          done    = 1'b1;
          hit     = 1'b1;
          wr_en_o = 1'b1;
          if (op_q == OP_INVAL) begin
            nxt_e     = '0;
            nxt_e.occ = 1'b1;   // tombstone keeps later walks going
          end else begin
            nxt_e.used  = 1'b1;
            nxt_e.dirty = cur.dirty | write_q;
          end
        end else if (!cur.occ || last) done = 1'b1;
      end
    end
  end

  assign wr_data_o = nxt_e;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      op_q        <= OP_LOOKUP;
      pid_q       <= '0;
      vpn_q       <= '0;
      off_q       <= '0;
      prot_q      <= '0;
      write_q     <= 1'b0;
      idx_q       <= '0;
      cnt_q       <= '0;
      frame_q     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_prot_o  <= '0;
      rsp_dirty_o <= 1'b0;
      rsp_used_o  <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (state_q == S_IDLE) begin
        if (req_valid_i) begin
          state_q <= S_PROBE;
          op_q    <= ipt_op_e'(req_op_i);
          pid_q   <= req_pid_i;
          vpn_q   <= req_vpn_i;
          off_q   <= req_off_i;
          prot_q  <= req_prot_i;
          write_q <= req_write_i;
          idx_q   <= start_idx_i;
          cnt_q   <= '0;
        end
      end else if (done) begin
        state_q     <= S_IDLE;
        rsp_valid_o <= 1'b1;
        rsp_hit_o   <= hit;
        frame_q     <= hit ? idx_q : '0;
        rsp_prot_o  <= !hit ? '0 : (op_q == OP_INSERT) ? prot_q : cur.prot;
        rsp_dirty_o <= hit && op_q != OP_INSERT && op_q != OP_INVAL && cur.dirty;
        rsp_used_o  <= hit && op_q != OP_INSERT && op_q != OP_INVAL && cur.used;
      end else begin
        idx_q <= (idx_q == IDX_W'(NUM_SLOTS - 1)) ? '0 : idx_q + 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rsp_frame_o = frame_q;
  assign rsp_paddr_o = {frame_q, off_q};

  assert_rsp_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !busy_o);
  assert_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o);
  assert_rsp_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_miss_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_frame_o == '0 && rsp_prot_o == '0));
  assert_probe_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && last) |=> !busy_o);
endmodule

// File: rtl/ipt_lookup_unit.sv
module ipt_lookup_unit #(
  parameter int NUM_SLOTS = 16,
  parameter int PID_W     = 6,
  parameter int VPN_W     = 20,
  parameter int OFF_W     = 12,
  parameter int PROT_W    = 3,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int ENTRY_W  = 4 + PROT_W + PID_W + VPN_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [1:0]             req_op_i,
  input  logic [PID_W-1:0]       req_pid_i,
  input  logic [VPN_W-1:0]       req_vpn_i,
  input  logic [OFF_W-1:0]       req_off_i,
  input  logic [PROT_W-1:0]      req_prot_i,
  input  logic                   req_write_i,
  output logic                   busy_o,
  output logic                   rsp_valid_o,
  output logic                   rsp_hit_o,
  output logic [IDX_W-1:0]       rsp_frame_o,
  output logic [IDX_W+OFF_W-1:0] rsp_paddr_o,
  output logic [PROT_W-1:0]      rsp_prot_o,
  output logic                   rsp_dirty_o,
  output logic                   rsp_used_o
);
  logic [IDX_W-1:0]   start_idx, rd_idx, wr_idx;
  logic [ENTRY_W-1:0] rd_data, wr_data;
  logic               wr_en;

  ipt_hash #(.PID_W(PID_W), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
    .pid_i (req_pid_i),
    .vpn_i (req_vpn_i),
    .idx_o (start_idx)
  );

  ipt_slot_array #(.NUM_SLOTS(NUM_SLOTS), .ENTRY_W(ENTRY_W)) u_slots (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data)
  );

  ipt_probe_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .PID_W(PID_W), .VPN_W(VPN_W),
    .OFF_W(OFF_W), .PROT_W(PROT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_pid_i   (req_pid_i),
    .req_vpn_i   (req_vpn_i),
    .req_off_i   (req_off_i),
    .req_prot_i  (req_prot_i),
    .req_write_i (req_write_i),
    .start_idx_i (start_idx),
    .rd_idx_o    (rd_idx),
    .rd_data_i   (rd_data),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .wr_data_o   (wr_data),
    .busy_o      (busy_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_hit_o   (rsp_hit_o),
    .rsp_frame_o (rsp_frame_o),
    .rsp_paddr_o (rsp_paddr_o),
    .rsp_prot_o  (rsp_prot_o),
    .rsp_dirty_o (rsp_dirty_o),
    .rsp_used_o  (rsp_used_o)
  );
endmodule

// File: tb/ipt_lookup_unit_test.sv
module ipt_lookup_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int N       = 8;
  localparam int PID_W   = 4;
  localparam int VPN_W   = 10;
  localparam int OFF_W   = 8;
  localparam int PROT_W  = 3;
  localparam int IDX_W   = $clog2(N);
  localparam int PADDR_W = IDX_W + OFF_W;
  localparam int EXP_W   = 1 + IDX_W + PADDR_W + PROT_W + 2;
  localparam int LOOKUP = 0, INSERT = 1, INVAL = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [1:0] req_op_i = '0;
  logic [PID_W-1:0] req_pid_i = '0;
  logic [VPN_W-1:0] req_vpn_i = '0;
  logic [OFF_W-1:0] req_off_i = '0;
  logic [PROT_W-1:0] req_prot_i = '0;
  logic req_write_i = 1'b0;
  logic busy_o, rsp_valid_o, rsp_hit_o, rsp_dirty_o, rsp_used_o;
  logic [IDX_W-1:0] rsp_frame_o;
  logic [PADDR_W-1:0] rsp_paddr_o;
  logic [PROT_W-1:0] rsp_prot_o;

  int n_checks = 0;
  int n_fail = 0;

  logic [EXP_W-1:0] exp_q[$];
  string tag_q[$];

  bit m_occ[N], m_live[N], m_dirty[N], m_used[N];
  int m_pid[N], m_vpn[N], m_prot[N];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipt_lookup_unit #(.NUM_SLOTS(N), .PID_W(PID_W), .VPN_W(VPN_W),
                    .OFF_W(OFF_W), .PROT_W(PROT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
    .req_pid_i(req_pid_i), .req_vpn_i(req_vpn_i), .req_off_i(req_off_i),
    .req_prot_i(req_prot_i), .req_write_i(req_write_i), .busy_o(busy_o),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_frame_o(rsp_frame_o),
    .rsp_paddr_o(rsp_paddr_o), .rsp_prot_o(rsp_prot_o), .rsp_dirty_o(rsp_dirty_o),
    .rsp_used_o(rsp_used_o));

  function automatic int start_slot(int pid, int vpn);
    int h = vpn % N;
    for (int i = 0; i < PID_W; i++)
      if ((pid >> i) & 1) h = h ^ (1 << (i % IDX_W));
    return h;
  endfunction

  task automatic check(string tag, logic [EXP_W-1:0] act, logic [EXP_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model, built from the requirement text
  task automatic model(int op, int pid, int vpn, int off, int prot, bit wr,
                       output logic [EXP_W-1:0] e);
    bit hit = 0, d = 0, u = 0;
    int fr = 0, pr = 0;
    int h = start_slot(pid, vpn);
    for (int p = 0; p < N; p++) begin
      int s = (h + p) % N;
      if (op == INSERT) begin
        if (!m_occ[s] || !m_live[s]) begin
          hit = 1; fr = s; pr = prot;
          m_occ[s] = 1; m_live[s] = 1; m_dirty[s] = 0; m_used[s] = 0;
          m_pid[s] = pid; m_vpn[s] = vpn; m_prot[s] = prot;
          break;
        end
      end else begin
        if (m_occ[s] && m_live[s] && m_pid[s] == pid && m_vpn[s] == vpn) begin
          hit = 1; fr = s; pr = m_prot[s];
          if (op == INVAL) begin
            m_live[s] = 0; m_dirty[s] = 0; m_used[s] = 0;
          end else begin
            d = m_dirty[s]; u = m_used[s];
            m_used[s] = 1; m_dirty[s] = m_dirty[s] | wr;
          end
          break;
        end
        if (!m_occ[s]) break;
      end
    end
    e = {hit, IDX_W'(fr), IDX_W'(fr), OFF_W'(off), PROT_W'(pr), d, u};
  endtask

  task automatic do_op(string tag, int op, int pid, int vpn, int off, int prot,
                       bit wr, bit spur);
    logic [EXP_W-1:0] e;
    model(op, pid, vpn, off, prot, wr, e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    while (busy_o) @(negedge clk);
    req_valid_i = 1'b1; req_op_i = 2'(op); req_pid_i = PID_W'(pid);
    req_vpn_i = VPN_W'(vpn); req_off_i = OFF_W'(off); req_prot_i = PROT_W'(prot);
    req_write_i = wr;
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R11 busy after accept", EXP_W'(busy_o), EXP_W'(1));
    if (spur) begin
      // R11: request during busy must be dropped
      req_valid_i = 1'b1; req_op_i = 2'(INSERT); req_pid_i = 4'd2;
      req_vpn_i = 10'd20; req_prot_i = 3'd7;
      @(negedge clk);
      req_valid_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R11 unexpected response: actual 1 expected 0");
      end else begin
        check(tag_q.pop_front(),
              {rsp_hit_o, rsp_frame_o, rsp_paddr_o, rsp_prot_o, rsp_dirty_o, rsp_used_o},
              exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset busy/valid", EXP_W'({busy_o, rsp_valid_o}), EXP_W'(0));
    do_op("R1 lookup after reset", LOOKUP, 1, 5, 8'h11, 0, 0, 0);
    do_op("R2 insert start slot", INSERT, 0, 3, 0, 3'd5, 0, 0);
    do_op("R2 pid fold insert", INSERT, 9, 2, 0, 3'd6, 0, 0);
    do_op("R3 lookup hit paddr", LOOKUP, 0, 3, 8'hA5, 0, 0, 0);
    do_op("R3 op code 3 as lookup", 3, 9, 2, 8'h3C, 0, 0, 0);
    do_op("R10 write hit", LOOKUP, 9, 2, 8'h01, 0, 1, 0);
    do_op("R10 dirty/used reported", LOOKUP, 9, 2, 8'h02, 0, 0, 0);
    do_op("R4 R6 other pid misses", LOOKUP, 1, 3, 8'h44, 0, 0, 0);
    do_op("R5 collision next slot", INSERT, 0, 11, 0, 3'd1, 0, 0);
    do_op("R6 R11 walk past mismatch", LOOKUP, 0, 11, 8'h77, 0, 0, 1);
    do_op("R11 dropped insert absent", LOOKUP, 2, 20, 8'h00, 0, 0, 0);
    do_op("R5 insert slot 7", INSERT, 0, 7, 0, 3'd2, 0, 0);
    do_op("R5 wrap to slot 0", INSERT, 0, 15, 0, 3'd3, 0, 0);
    do_op("R5 lookup wrapped", LOOKUP, 0, 15, 8'h9E, 0, 0, 0);
    do_op("R8 invalidate live", INVAL, 0, 3, 0, 0, 0, 0);
    do_op("R8 lookup removed", LOOKUP, 0, 3, 8'h10, 0, 0, 0);
    do_op("R8 found past tombstone", LOOKUP, 0, 11, 8'h20, 0, 0, 0);
    do_op("R8 invalidate absent", INVAL, 5, 5, 0, 0, 0, 0);
    do_op("R9 reuse tombstone", INSERT, 0, 19, 0, 3'd4, 0, 0);
    do_op("R10 insert clears flags", LOOKUP, 0, 19, 8'h30, 0, 0, 0);
    do_op("R7 fill a", INSERT, 3, 1, 0, 3'd1, 0, 0);
    do_op("R7 fill b", INSERT, 4, 6, 0, 3'd2, 0, 0);
    do_op("R7 fill c", INSERT, 6, 9, 0, 3'd3, 0, 0);
    do_op("R7 insert full fails", INSERT, 7, 12, 0, 3'd5, 0, 0);
    do_op("R7 lookup full misses", LOOKUP, 7, 12, 8'h55, 0, 0, 0);
    do_op("R3 hit after fill", LOOKUP, 4, 6, 8'hEE, 0, 0, 0);
    repeat (4) @(negedge clk);
    check("R11 all responses seen", EXP_W'(exp_q.size()), EXP_W'(0));
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule